// File: doc/BRIEF.md
# Interlaced Video Timing Generator

This block produces the raster timing for a display output. A line is made of four horizontal phases (sync, back porch, active, front porch), each a programmable number of clocks. A field or frame is made of the same four phases in the vertical direction, each a programmable number of lines. The outputs are a horizontal sync, a vertical sync, a data-enable that marks visible pixels, a field flag and an interrupt line.

For interlaced output, fields alternate between a primary (odd) set of vertical lengths and a separate even-field set. In the odd field the vertical sync can be shifted by a programmable number of clocks. The start of every horizontal and vertical phase, the end of the vertical front porch and the return to idle each latch a status bit. A mask selects which latched bits drive the interrupt. All settings are loaded through a simple write port. Status bits are cleared by writing ones.

The generator runs either continuously or for a single frame. After a single frame it stops and flags that it is idle.

Top module: `scan_timing_gen`

## Requirements
- R1: After reset hsync, vsync, de, field and irq are low and evt_flags is zero.
- R2: Horizontal timing comes from word address 1 (sync length in bits 15:0, back porch length in bits 31:16) and word address 2 (active length in bits 15:0, front porch length in bits 31:16). Phases run sync, back porch, active, front porch. A length N gives exactly N clocks, and hsync is high during the sync phase only.
- R3: Vertical timing comes from word addresses 3 and 4, in lines, with the same field layout as R2. Vsync is high during the lines of the vertical sync phase. A line is one full horizontal cycle.
- R4: de is high only in clocks where both the horizontal and the vertical phase are active.
- R5: evt_flags latches these events: bit 0 hsync start, bit 1 horizontal back porch start, bit 2 horizontal active start, bit 3 horizontal front porch start, bit 4 vsync start, bit 5 vertical back porch start, bit 6 vertical active start, bit 7 vertical front porch start, bit 8 vertical front porch end, bit 9 video idle. A vertical phase start is flagged in the first clock of its first line.
- R6: Word address 7 holds a 10-bit mask. irq is the OR of the evt_flags bits whose mask bit is 1.
- R7: Writing to address 8 clears every evt_flags bit written as 1. An event in the same clock as the clear leaves its bit set.
- R8: Control word address 0 holds: bit 0 enable, bit 1 continuous, bit 4 interlace, bit 5 odd field first, bits 22:6 odd-field delay. With continuous off, the generator runs one frame (two fields when interlaced), then drops all outputs and raises video idle. It does not restart until enable has been cleared and set again.
- R9: With continuous on, frames (or fields) follow one another with no gap.
- R10: With interlace on, fields alternate. The even field uses the vertical words at addresses 5 and 6, and the field output is 1 during it. Odd field first selects which field comes first.
- R11: In an odd field with interlace on, both vsync edges come D clocks after the vertical sync phase edges, where D is the programmed delay. D must be shorter than the vertical sync phase in clocks.
- R12: Clearing enable while running stops the generator one clock later, drops all outputs and raises video idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the setting port |
| wr_addr | input | 4 | Word address of the write |
| wr_data | input | 32 | Write data |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync, shifted in odd interlaced fields |
| de | output | 1 | Data enable for visible pixels |
| field | output | 1 | 1 during the even field |
| irq | output | 1 | Masked OR of the latched events |
| evt_flags | output | 10 | Latched event bits |

## Verification
Latching a phase-start event and a write-one-to-clear of the same status bit can land in one clock. The bench provokes this by watching for the first clock of hsync and issuing a clear of bit 0 so that it is sampled on that clock's edge. It then expects the bit to remain set. A second clear one clock later, with no event present, must drop the bit, which shows that the clear itself works. Stopping on a dropped enable is judged against outputs that go low and a video idle flag raised one clock after the enable write takes effect.

// File: rtl/stg_pkg.sv
package stg_pkg;

  typedef enum logic [1:0] {
    PH_SYNC  = 2'd0,
    PH_BACK  = 2'd1,
    PH_ACT   = 2'd2,
    PH_FRONT = 2'd3
  } phase_e;

  localparam int NUM_EV     = 10;
  localparam int EV_H_BASE  = 0;
  localparam int EV_V_BASE  = 4;
  localparam int EV_VF_END  = 8;
  localparam int EV_IDLE    = 9;

  localparam int CTL_EN     = 0;
  localparam int CTL_CONT   = 1;
  localparam int CTL_ILACE  = 4;
  localparam int CTL_ODD1ST = 5;
  localparam int CTL_DLY_LO = 6;

  localparam int A_CTL      = 0;
  localparam int A_HORZ_A   = 1;
  localparam int A_HORZ_B   = 2;
  localparam int A_VPRI_A   = 3;
  localparam int A_VPRI_B   = 4;
  localparam int A_VEVN_A   = 5;
  localparam int A_VEVN_B   = 6;
  localparam int A_MASK     = 7;
  localparam int A_CLR      = 8;
  localparam int N_WORDS    = 7;

endpackage

// File: rtl/stg_regs.sv
module stg_regs
  import stg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [ADDR_W-1:0]               wr_addr,
  input  logic [DATA_W-1:0]               wr_data,
  input  logic [NUM_EV-1:0]               ev,
  output logic [N_WORDS-1:0][DATA_W-1:0]  words,
  output logic [NUM_EV-1:0]               status,
  output logic                            irq
);

  for (genvar w = 0; w < N_WORDS; w++) begin : g_word
    logic              ld;
    logic [DATA_W-1:0] q;
    assign ld = wr_en && (wr_addr == ADDR_W'(w));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (ld) q <= wr_data;
    end
    assign words[w] = q;
  end

  logic              mask_ld;
  logic [NUM_EV-1:0] mask_q;
  logic [NUM_EV-1:0] clr_vec;
  logic [NUM_EV-1:0] st_q, st_d;

  assign mask_ld = wr_en && (wr_addr == ADDR_W'(A_MASK));
  assign clr_vec = (wr_en && (wr_addr == ADDR_W'(A_CLR))) ? wr_data[NUM_EV-1:0] : '0;

  always_comb begin
    st_d = (st_q & ~clr_vec) | ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_ld) mask_q <= wr_data[NUM_EV-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign status = st_q;
  assign irq    = |(st_q & mask_q);

  // R7
  event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev != '0) |=> ((st_q & $past(ev)) == $past(ev)));

endmodule

// File: rtl/stg_phase_cnt.sv
module stg_phase_cnt
  import stg_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  input  logic [LEN_W-1:0] len_sync,
  input  logic [LEN_W-1:0] len_back,
  input  logic [LEN_W-1:0] len_act,
  input  logic [LEN_W-1:0] len_front,
  output phase_e           phase,
  output logic             first,
  output logic             last,
  output logic             wrap
);

  localparam int CW = LEN_W + 1;

  phase_e           ph_q, ph_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic [LEN_W-1:0] cur_len;

  always_comb begin
    case (ph_q)
      PH_SYNC: cur_len = len_sync;
      PH_BACK: cur_len = len_back;
      PH_ACT:  cur_len = len_act;
      default: cur_len = len_front;
    endcase
  end

  // a zero length behaves as one clock
  assign last  = ({1'b0, cnt_q} + CW'(1)) >= {1'b0, cur_len};
  assign first = (cnt_q == '0);
  assign wrap  = last && (ph_q == PH_FRONT);

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    if (clr) begin
      ph_d  = PH_SYNC;
      cnt_d = '0;
    end else if (adv) begin
      if (last) begin
        ph_d  = phase_e'(ph_q + 2'd1);
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_SYNC;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  assign phase = ph_q;

  // R2
  front_to_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && adv && last && ph_q == PH_FRONT) |=> (ph_q == PH_SYNC && cnt_q == '0));

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !adv) |=> ($stable(ph_q) && $stable(cnt_q)));

endmodule

// File: rtl/stg_seq.sv
module stg_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic cont,
  input  logic ilace,
  input  logic odd_first,
  input  logic h_wrap,
  input  logic v_wrap,
  output logic run,
  output logic field_even,
  output logic cnt_clr,
  output logic field_end,
  output logic stop
);

  logic run_q, run_d;
  logic done_q, done_d;
  logic even_q, even_d;
  logic second_q, second_d;
  logic start;

  assign field_end = run_q & h_wrap & v_wrap;
  assign start     = !run_q & en & !done_q;
  assign stop      = run_q & (!en | (field_end & !cont & (!ilace | second_q)));

  always_comb begin
    run_d    = run_q;
    done_d   = done_q;
    even_d   = even_q;
    second_d = second_q;
    if (start) begin
      run_d    = 1'b1;
      done_d   = 1'b0;
      second_d = 1'b0;
      even_d   = ilace & !odd_first;
    end else if (stop) begin
      run_d  = 1'b0;
      done_d = en;
    end else if (field_end) begin
      second_d = !second_q;
      even_d   = ilace & !even_q;
    end
    if (!en) done_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      done_q   <= 1'b0;
      even_q   <= 1'b0;
      second_q <= 1'b0;
    end else begin
      run_q    <= run_d;
      done_q   <= done_d;
      even_q   <= even_d;
      second_q <= second_d;
    end
  end

  assign run        = run_q;
  assign field_even = even_q;
  assign cnt_clr    = !run_q;

  // R12
  en_low_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !run_q);

  // R8
  single_frame_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (field_end && !cont && !ilace) |=> !run_q);

  // R10
  field_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (field_end && ilace && cont && en) |=> (even_q != $past(even_q)));

endmodule

// File: rtl/stg_odd_vsync.sv
module stg_odd_vsync #(
  parameter int DLY_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             odd_sel,
  input  logic             vs_raw,
  input  logic [DLY_W-1:0] dly,
  output logic             vs_out
);

  logic             seen_q, seen_d;
  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic             chg;
  logic             shifted;

  assign chg = (vs_raw != seen_q);

  always_comb begin
    seen_d = seen_q;
    cnt_d  = cnt_q;
    if (!run) begin
      seen_d = 1'b0;
      cnt_d  = '0;
    end else if (chg) begin
      seen_d = vs_raw;
      cnt_d  = dly;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      seen_q <= seen_d;
      cnt_q  <= cnt_d;
    end
  end

  always_comb begin
    if (chg) shifted = (dly == '0) ? vs_raw : seen_q;
    else     shifted = (cnt_q <= DLY_W'(1)) ? seen_q : !seen_q;
  end

  assign vs_out = run & (odd_sel ? shifted : vs_raw);

  // R11
  odd_edge_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && odd_sel && chg && dly > DLY_W'(1)) |=>
      (!run || !odd_sel || vs_out == $past(seen_q)));

endmodule

// File: rtl/scan_timing_gen.sv
module scan_timing_gen
  import stg_pkg::*;
#(
  parameter int LEN_W  = 16,
  parameter int DLY_W  = 17,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              hsync,
  output logic              vsync,
  output logic              de,
  output logic              field,
  output logic              irq,
  output logic [NUM_EV-1:0] evt_flags
);

  localparam int DLY_HI = CTL_DLY_LO + DLY_W;

  logic [N_WORDS-1:0][DATA_W-1:0] words;
  logic [DATA_W-1:0] ctl;
  logic [NUM_EV-1:0] ev;

  stg_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ev(ev), .words(words), .status(evt_flags), .irq(irq)
  );

  assign ctl = words[A_CTL];

  logic             en, cont, ilace, odd_first;
  logic [DLY_W-1:0] dly;
  assign en        = ctl[CTL_EN];
  assign cont      = ctl[CTL_CONT];
  assign ilace     = ctl[CTL_ILACE];
  assign odd_first = ctl[CTL_ODD1ST];
  assign dly       = ctl[CTL_DLY_LO +: DLY_W];

  logic run, field_even, cnt_clr, field_end, stop;
  logic h_first, h_last, h_wrap;
  logic v_first, v_last, v_wrap;
  phase_e h_phase, v_phase;

  stg_seq u_seq (
    .clk(clk), .rst_n(rst_n), .en(en), .cont(cont), .ilace(ilace),
    .odd_first(odd_first), .h_wrap(h_wrap), .v_wrap(v_wrap), .run(run),
    .field_even(field_even), .cnt_clr(cnt_clr), .field_end(field_end), .stop(stop)
  );

  stg_phase_cnt #(.LEN_W(LEN_W)) u_hcnt (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .adv(run),
    .len_sync (words[A_HORZ_A][LEN_W-1:0]),
    .len_back (words[A_HORZ_A][2*LEN_W-1:LEN_W]),
    .len_act  (words[A_HORZ_B][LEN_W-1:0]),
    .len_front(words[A_HORZ_B][2*LEN_W-1:LEN_W]),
    .phase(h_phase), .first(h_first), .last(h_last), .wrap(h_wrap)
  );

  logic              use_even;
  logic [DATA_W-1:0] vw_a, vw_b;
  assign use_even = ilace & field_even;

  always_comb begin
    if (use_even) begin
      vw_a = words[A_VEVN_A];
      vw_b = words[A_VEVN_B];
    end else begin
      vw_a = words[A_VPRI_A];
      vw_b = words[A_VPRI_B];
    end
  end

  stg_phase_cnt #(.LEN_W(LEN_W)) u_vcnt (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .adv(run & h_wrap),
    .len_sync (vw_a[LEN_W-1:0]),
    .len_back (vw_a[2*LEN_W-1:LEN_W]),
    .len_act  (vw_b[LEN_W-1:0]),
    .len_front(vw_b[2*LEN_W-1:LEN_W]),
    .phase(v_phase), .first(v_first), .last(v_last), .wrap(v_wrap)
  );

  logic line_start;
  assign line_start = h_first & (h_phase == PH_SYNC);

  for (genvar p = 0; p < 4; p++) begin : g_ev
    assign ev[EV_H_BASE + p] = run & h_first & (h_phase == phase_e'(2'(p)));
    assign ev[EV_V_BASE + p] = run & line_start & v_first & (v_phase == phase_e'(2'(p)));
  end
  assign ev[EV_VF_END] = field_end;
  assign ev[EV_IDLE]   = stop;

  logic vs_raw;
  assign vs_raw = run & (v_phase == PH_SYNC);

  stg_odd_vsync #(.DLY_W(DLY_W)) u_vdly (
    .clk(clk), .rst_n(rst_n), .run(run), .odd_sel(ilace & !field_even),
    .vs_raw(vs_raw), .dly(dly), .vs_out(vsync)
  );

  assign hsync = run & (h_phase == PH_SYNC);
  assign de    = run & (h_phase == PH_ACT) & (v_phase == PH_ACT);
  assign field = run & field_even;

  logic unused_bits;
  assign unused_bits = ^{ctl[DATA_W-1:DLY_HI], ctl[3:2], h_last, v_last};

  // R4
  de_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> (!hsync && !vs_raw));

endmodule

// File: tb/sim_scan_timing_gen.sv
module sim_scan_timing_gen;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  wr_addr;
  logic [31:0] wr_data;
  logic        hsync, vsync, de, field, irq;
  logic [9:0]  evt_flags;

  int total = 0;
  int bad   = 0;

  scan_timing_gen u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hsync(hsync), .vsync(vsync), .de(de), .field(field), .irq(irq), .evt_flags(evt_flags)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // model configuration
  int hs_len, hb_len, ha_len, hf_len;
  int va[4];
  int vb[4];
  bit a_even, b_even, ilace_cfg;
  int dly_cfg;

  localparam int D_ODD = 5;

  task automatic check(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
  endtask

  function automatic void model(input int t, output bit e_hs, output bit e_vs,
                                output bit e_de, output bit e_fd);
    int lw, fa, ft, ln, pos, d;
    int v[4];
    bit ev;
    lw = hs_len + hb_len + ha_len + hf_len;
    fa = lw * (va[0] + va[1] + va[2] + va[3]);
    if (t < fa) begin ft = t;      v = va; ev = a_even; end
    else        begin ft = t - fa; v = vb; ev = b_even; end
    d   = (ilace_cfg && !ev) ? dly_cfg : 0;
    ln  = ft / lw;
    pos = ft % lw;
    e_hs = pos < hs_len;
    e_de = (pos >= hs_len + hb_len) && (pos < hs_len + hb_len + ha_len) &&
           (ln >= v[0] + v[1]) && (ln < v[0] + v[1] + v[2]);
    e_vs = (ft >= d) && (((ft - d) / lw) < v[0]);
    e_fd = ev;
  endfunction

  task automatic compare_span(input int n, input string rq_v);
    int mh = 0, mv = 0, md = 0, mf = 0, guard = 0;
    bit eh, evs, ed, ef;
    while (hsync !== 1'b1 && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
    for (int t = 0; t < n; t++) begin
      model(t, eh, evs, ed, ef);
      if (hsync !== eh)  mh++;
      if (vsync !== evs) mv++;
      if (de !== ed)     md++;
      if (field !== ef)  mf++;
      @(negedge clk);
    end
    check(mh == 0, "R2", "hsync mismatch cycles", mh, 0);
    check(mv == 0, rq_v, "vsync mismatch cycles", mv, 0);
    check(md == 0, "R4", "de mismatch cycles", md, 0);
    check(mf == 0, "R10", "field mismatch cycles", mf, 0);
  endtask

  task automatic idle_check(input int n, input string rq);
    int busy = 0;
    for (int i = 0; i < n; i++) begin
      if (hsync || vsync || de || field) busy++;
      @(negedge clk);
    end
    check(busy == 0, rq, "active cycles while idle", busy, 0);
  endtask

  task automatic set_h();
    hs_len = 3; hb_len = 2; ha_len = 5; hf_len = 4;
    wr(1, {16'(hb_len), 16'(hs_len)});
    wr(2, {16'(hf_len), 16'(ha_len)});
  endtask

  task automatic set_v();
    wr(3, {16'd1, 16'd2});
    wr(4, {16'd2, 16'd3});
    wr(5, {16'd2, 16'd1});
    wr(6, {16'd1, 16'd2});
  endtask

  function automatic void odd_v(output int v[4]);
    v[0] = 2; v[1] = 1; v[2] = 3; v[3] = 2;
  endfunction

  function automatic void even_v(output int v[4]);
    v[0] = 1; v[1] = 2; v[2] = 2; v[3] = 1;
  endfunction

  // R1
  task automatic test_reset();
    check(hsync == 1'b0, "R1", "hsync after reset", hsync, 0);
    check(vsync == 1'b0, "R1", "vsync after reset", vsync, 0);
    check(de == 1'b0, "R1", "de after reset", de, 0);
    check(field == 1'b0, "R1", "field after reset", field, 0);
    check(irq == 1'b0, "R1", "irq after reset", irq, 0);
    check(evt_flags == 10'h0, "R1", "evt_flags after reset", evt_flags, 0);
  endtask

  // R2 R3 R4 R5 R8
  task automatic test_single_frame();
    set_h(); set_v();
    odd_v(va); odd_v(vb);
    a_even = 0; b_even = 0; ilace_cfg = 0; dly_cfg = 0;
    wr(8, 32'h3FF);
    wr(0, 32'h1);
    compare_span(112, "R3");
    check(evt_flags == 10'h3FF, "R5", "all phase events latched", evt_flags, 10'h3FF);
    idle_check(40, "R8");
  endtask

  // R6 R7
  task automatic test_irq_mask();
    wr(7, 32'h0);
    @(negedge clk);
    check(irq == 1'b0, "R6", "irq with empty mask", irq, 0);
    wr(7, 32'h200);
    check(irq == 1'b1, "R6", "irq with idle bit enabled", irq, 1);
    wr(8, 32'h200);
    check(evt_flags == 10'h1FF, "R7", "clear of idle bit", evt_flags, 10'h1FF);
    check(irq == 1'b0, "R6", "irq after masked bit cleared", irq, 0);
    wr(8, 32'h3FF);
    check(evt_flags == 10'h0, "R7", "clear of all bits", evt_flags, 0);
  endtask

  // R9 R7 R12
  task automatic test_continuous();
    bit prev;
    int g = 0;
    wr(0, 32'h0);
    wr(8, 32'h3FF);
    odd_v(va); odd_v(vb);
    a_even = 0; b_even = 0; ilace_cfg = 0; dly_cfg = 0;
    wr(0, 32'h3);
    compare_span(224, "R9");
    prev = hsync;
    @(negedge clk);
    while (!(hsync && !prev) && g < 100) begin
      prev = hsync;
      @(negedge clk);
      g++;
    end
    // clear lands on the same edge as the hsync start event
    wr_en = 1'b1; wr_addr = 4'd8; wr_data = 32'h1;
    @(negedge clk);
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    check(evt_flags[0] == 1'b1, "R7", "event wins over same-cycle clear", evt_flags[0], 1);
    wr(8, 32'h1);
    check(evt_flags[0] == 1'b0, "R7", "clear without event", evt_flags[0], 0);
    check(evt_flags[9] == 1'b0, "R12", "idle bit before disable", evt_flags[9], 0);
    wr(0, 32'h0);
    @(negedge clk);
    check(hsync == 0 && vsync == 0 && de == 0, "R12", "outputs after disable",
          {hsync, vsync, de}, 0);
    check(evt_flags[9] == 1'b1, "R12", "idle bit after disable", evt_flags[9], 1);
    idle_check(20, "R12");
  endtask

  // R10 R11 R8
  task automatic test_interlace(input bit odd_first);
    wr(8, 32'h3FF);
    ilace_cfg = 1; dly_cfg = D_ODD;
    if (odd_first) begin
      odd_v(va); even_v(vb); a_even = 0; b_even = 1;
    end else begin
      even_v(va); odd_v(vb); a_even = 1; b_even = 0;
    end
    wr(0, 32'h1 | (32'h1 << 4) | (32'(odd_first) << 5) | (32'(D_ODD) << 6));
    compare_span(196, "R11");
    check(evt_flags[9] == 1'b1, "R8", "idle after two fields", evt_flags[9], 1);
    idle_check(30, "R8");
    wr(0, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_single_frame();
    test_irq_mask();
    test_continuous();
    test_interlace(1'b1);
    test_interlace(1'b0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog (all requirements) actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule